// File: doc/BRIEF.md
# Conditional Relative Branch Unit

This block works out the next program counter for the short relative-branch instruction class of a processor with a 24-bit address space. Each such instruction is two bytes long. The first byte carries a 4-bit condition selector. The second byte is a signed 8-bit displacement. The instruction sequencer presents the following inputs with a one-cycle strobe:

- the selector;
- the displacement;
- the program counter, already advanced past the instruction;
- the four status flags: zero, negative, overflow and carry.

One clock later the block returns three results: the next program counter, a taken indication, and a request to push a return address. The push request is raised only for the relative-call selector.

Selector values 0 to 13 are true conditions built from the flags. Selector 14 is a relative call and is always taken. Selector 15 is an unconditional branch. A taken branch adds the sign-extended displacement to the advanced program counter, modulo 2^24. A branch that is not taken continues at the advanced program counter.

For a call, the block only supplies the return address. The sequencer writes it to the stack as three bytes, least significant byte first. The stack memory and instruction fetch lie outside the block.

Top module: `relbr_unit`

## Requirements
- R1: While reset (rst_n low) is asserted, and on the first edge after it, res_valid, br_taken and ret_push are 0.
- R2: Selectors 0..7 test a single flag. 0 is taken when Z=0, 1 when Z=1, 2 when C=0, 3 when C=1, 4 when N=0, 5 when N=1, 6 when V=0, and 7 when V=1.
- R3: The signed selectors are as follows. 8 is taken when (N xor V)=0. 9 is taken when (N xor V)=1. 10 is taken when neither Z=1 nor (N xor V)=1. 11 is taken when Z=1 or (N xor V)=1.
- R4: The unsigned selectors are as follows. 12 is taken when neither Z=1 nor C=0. 13 is taken when Z=1 or C=0.
- R5: Selector 15 is always taken with ret_push=0. Selector 14 is always taken with ret_push=1, and ret_addr then equals the advanced program counter that was presented with it.
- R6: When taken, next_pc equals seq_pc plus the 8-bit displacement sign-extended to 24 bits, wrapping modulo 2^24. For example, 0xFFFFFF+0x01 gives 0x000000, and 0x000000+0xFF gives 0xFFFFFF.
- R7: When not taken, next_pc equals seq_pc, and ret_push is 0.
- R8: The results appear with res_valid=1 exactly one clock after req_valid=1. In any cycle with res_valid=0, br_taken and ret_push are 0.
- R9: ret_push is 1 only for selector 14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A branch instruction is presented this cycle |
| cond_sel | input | 4 | Condition selector from the opcode byte |
| disp | input | 8 | Signed displacement byte |
| seq_pc | input | 24 | Program counter past the two-byte instruction |
| flag_z | input | 1 | Zero flag |
| flag_n | input | 1 | Negative flag |
| flag_v | input | 1 | Overflow flag |
| flag_c | input | 1 | Carry flag |
| res_valid | output | 1 | Results below are valid |
| next_pc | output | 24 | Program counter to fetch from next |
| br_taken | output | 1 | The branch or call is taken |
| ret_push | output | 1 | Request to push ret_addr as a return address |
| ret_addr | output | 24 | Return address for a call |

## Verification
The hardest cases to reach are the compound signed and unsigned selectors. Their polarity only shows up under flag mixes where Z disagrees with N xor V, or where Z disagrees with C. The stimulus therefore sweeps every one of the 16 selectors against all 16 flag combinations, so every such split is visited.

The address wrap at both ends of the 24-bit space needs a program counter near 0 or near 0xFFFFFF paired with a displacement of the right sign. These cases are driven directly, alongside the extreme displacements +127 and -128.

// File: rtl/relbr_pkg.sv
package relbr_pkg;
  localparam int ADDR_W = 24;
  localparam int DISP_W = 8;
  localparam int SEL_W  = 4;
  localparam logic [SEL_W-1:0] SEL_CALL   = 4'hE;
  localparam logic [SEL_W-1:0] SEL_ALWAYS = 4'hF;

  typedef struct packed {
    logic z;
    logic n;
    logic v;
    logic c;
  } flags_t;

  // Selectors 0..13 come in pairs: an even code takes the inverse of a
  // base term, an odd code takes the term itself.
  function automatic logic sel_term(input logic [SEL_W-2:0] grp, input flags_t f);
    logic lt;
    lt = f.n ^ f.v;
    case (grp)
      3'd0:    sel_term = f.z;
      3'd1:    sel_term = f.c;
      3'd2:    sel_term = f.n;
      3'd3:    sel_term = f.v;
      3'd4:    sel_term = lt;
      3'd5:    sel_term = f.z | lt;
      3'd6:    sel_term = f.z | ~f.c;
      default: sel_term = 1'b1;
    endcase
  endfunction

  function automatic logic [ADDR_W-1:0] rel_target(input logic [ADDR_W-1:0] pc,
                                                   input logic [DISP_W-1:0] d);
    logic [ADDR_W-1:0] ext;
    ext = {{(ADDR_W-DISP_W){d[DISP_W-1]}}, d};
    rel_target = pc + ext;
  endfunction
endpackage

// File: rtl/relbr_cond_eval.sv
module relbr_cond_eval
  import relbr_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  input  flags_t           flags,
  output logic             cond_hit,
  output logic             is_call
);
  logic fixed_take;
  logic term;

  assign fixed_take = (sel == SEL_CALL) || (sel == SEL_ALWAYS);
  assign term       = sel_term(sel[SEL_W-1:1], flags);
  assign cond_hit   = fixed_take ? 1'b1 : (sel[0] ? term : ~term);
  assign is_call    = (sel == SEL_CALL);
endmodule

// File: rtl/relbr_target.sv
module relbr_target
  import relbr_pkg::*;
(
  input  logic [ADDR_W-1:0] pc,
  input  logic [DISP_W-1:0] d,
  input  logic              take,
  output logic [ADDR_W-1:0] dest
);
  logic [ADDR_W-1:0] jump_pc;

  assign jump_pc = rel_target(pc, d);
  assign dest    = take ? jump_pc : pc;
endmodule

// File: rtl/relbr_unit.sv
module relbr_unit
  import relbr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [SEL_W-1:0]  cond_sel,
  input  logic [DISP_W-1:0] disp,
  input  logic [ADDR_W-1:0] seq_pc,
  input  logic              flag_z,
  input  logic              flag_n,
  input  logic              flag_v,
  input  logic              flag_c,
  output logic              res_valid,
  output logic [ADDR_W-1:0] next_pc,
  output logic              br_taken,
  output logic              ret_push,
  output logic [ADDR_W-1:0] ret_addr
);
  flags_t            cur_flags;
  logic              cond_hit;
  logic              is_call;
  logic [ADDR_W-1:0] dest_pc;

  assign cur_flags = '{z: flag_z, n: flag_n, v: flag_v, c: flag_c};

  relbr_cond_eval u_cond (
    .sel      (cond_sel),
    .flags    (cur_flags),
    .cond_hit (cond_hit),
    .is_call  (is_call)
  );

  relbr_target u_tgt (
    .pc   (seq_pc),
    .d    (disp),
    .take (cond_hit),
    .dest (dest_pc)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      br_taken  <= 1'b0;
      ret_push  <= 1'b0;
      next_pc   <= '0;
      ret_addr  <= '0;
    end else begin
      res_valid <= req_valid;
      br_taken  <= req_valid & cond_hit;
      ret_push  <= req_valid & is_call;
      next_pc   <= dest_pc;
      ret_addr  <= seq_pc;
    end
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!br_taken && !ret_push)); // R8
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid); // R8
  AST_PUSH_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push |-> br_taken); // R5
  AST_PUSH_ONLY_CALL: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push |-> ($past(cond_sel) == SEL_CALL)); // R9
  AST_RET_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ret_push |-> (ret_addr == $past(seq_pc))); // R5
  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && $past(cond_sel) == SEL_ALWAYS) |-> (br_taken && !ret_push)); // R5
  AST_FALLTHRU: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !br_taken) |-> (next_pc == $past(seq_pc) && !ret_push)); // R7
endmodule

// File: tb/relbr_unit_tb.sv
`timescale 1ns/1ps
module relbr_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [3:0]  cond_sel = '0;
  logic [7:0]  disp = '0;
  logic [23:0] seq_pc = '0;
  logic        flag_z = 0, flag_n = 0, flag_v = 0, flag_c = 0;
  logic        res_valid, br_taken, ret_push;
  logic [23:0] next_pc, ret_addr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic        taken;
    logic        push;
    logic [23:0] npc;
    logic [23:0] raddr;
    string       req;
  } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  relbr_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_sel(cond_sel),
    .disp(disp), .seq_pc(seq_pc), .flag_z(flag_z), .flag_n(flag_n),
    .flag_v(flag_v), .flag_c(flag_c), .res_valid(res_valid),
    .next_pc(next_pc), .br_taken(br_taken), .ret_push(ret_push),
    .ret_addr(ret_addr)
  );

  // Independent reference: one explicit case per selector.
  function automatic logic ref_take(input logic [3:0] s, input logic z, n, v, c);
    case (s)
      4'h0: return z == 0;
      4'h1: return z == 1;
      4'h2: return c == 0;
      4'h3: return c == 1;
      4'h4: return n == 0;
      4'h5: return n == 1;
      4'h6: return v == 0;
      4'h7: return v == 1;
      4'h8: return n == v;
      4'h9: return n != v;
      4'hA: return (z == 0) && (n == v);
      4'hB: return (z == 1) || (n != v);
      4'hC: return (z == 0) && (c == 1);
      4'hD: return (z == 1) || (c == 0);
      default: return 1'b1;
    endcase
  endfunction

  function automatic string req_of(input logic [3:0] s);
    if (s < 4'h8) return "R2";
    if (s < 4'hC) return "R3";
    if (s < 4'hE) return "R4";
    return "R5";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] s, input logic [7:0] d, input logic [23:0] pc,
                       input logic [3:0] f);
    exp_t e;
    int signed off;
    @(negedge clk);
    req_valid = 1; cond_sel = s; disp = d; seq_pc = pc;
    {flag_z, flag_n, flag_v, flag_c} = f;
    e.taken = ref_take(s, f[3], f[2], f[1], f[0]);
    e.push  = (s == 4'hE);
    off = (d >= 8'h80) ? int'(d) - 256 : int'(d);
    e.npc   = e.taken ? 24'(int'(pc) + off) : pc;
    e.raddr = pc;
    e.req   = req_of(s);
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      req_valid = 0;
      cond_sel = $urandom; seq_pc = $urandom; disp = $urandom;
    end
  endtask

  // Monitor: sample 1 ns after each rising edge.
  initial begin
    forever begin
      @(posedge clk); #1;
      if (rst_n) begin
        if (res_valid) begin
          if (sb.size() == 0) begin
            check(0, "R8", "unexpected res_valid", 1, 0);
          end else begin
            exp_t e;
            e = sb.pop_front();
            check(br_taken == e.taken, e.req, "br_taken", 32'(br_taken), 32'(e.taken));
            check(ret_push == e.push, "R9", "ret_push", 32'(ret_push), 32'(e.push));
            check(next_pc == e.npc, e.taken ? "R6" : "R7", "next_pc", 32'(next_pc), 32'(e.npc));
            if (e.push)
              check(ret_addr == e.raddr, "R5", "ret_addr", 32'(ret_addr), 32'(e.raddr));
          end
        end else begin
          check(!br_taken && !ret_push, "R8", "idle outputs quiet",
                32'({br_taken, ret_push}), 0);
          check(sb.size() == 0, "R8", "result missing", 32'(sb.size()), 0);
        end
      end
    end
  end

  initial begin
    #200000;
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    req_valid = 1;
    cond_sel = 4'hE;
    repeat (3) @(posedge clk);
    #1;
    check(!res_valid && !br_taken && !ret_push, "R1", "reset outputs",
          32'({res_valid, br_taken, ret_push}), 0);
    @(negedge clk);
    req_valid = 0;
    rst_n = 1;
    @(posedge clk); #1;
    check(!res_valid && !ret_push, "R1", "first edge after reset",
          32'({res_valid, ret_push}), 0);

    // Full sweep: every selector against every flag mix.
    for (int s = 0; s < 16; s++)
      for (int f = 0; f < 16; f++)
        issue(4'(s), 8'(s * 17 + f * 5), 24'(32'h123456 + s * 4099 + f * 257), 4'(f));
    idle(2);

    // Wrap and extreme displacements (R6).
    issue(4'hF, 8'h01, 24'hFFFFFF, 4'h0);
    issue(4'hF, 8'hFF, 24'h000000, 4'h0);
    issue(4'hF, 8'h7F, 24'hFFFFC0, 4'h0);
    issue(4'hF, 8'h80, 24'h000010, 4'h0);
    issue(4'hE, 8'h80, 24'h800000, 4'h0);
    issue(4'hE, 8'h02, 24'hFFFFFE, 4'hF);
    idle(1);
    // Not taken near the wrap (R7).
    issue(4'h1, 8'h80, 24'h000000, 4'h0);
    issue(4'h0, 8'h7F, 24'hFFFFFF, 4'h8);
    idle(1);
    // Random spot checks with gaps.
    for (int k = 0; k < 200; k++) begin
      issue(4'($urandom), 8'($urandom), 24'($urandom), 4'($urandom));
      if (k % 7 == 0) idle(1);
    end
    idle(4);
    check(sb.size() == 0, "R8", "scoreboard drained", 32'(sb.size()), 0);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule